// File: doc/BRIEF.md
# Segment-Based Address Translator with Access Protection

This block turns a logical address, made of a segment number and an offset within that segment, into a physical address. It uses a small table of segment descriptors held in flip-flops. Each descriptor has four fields:

- a present flag;
- three permission flags: read, write and execute;
- a length in bytes, which may be anything from zero up to the full range of the offset;
- a physical base address.

A request from the processor is checked in three steps, and the first step that fails decides the outcome:

1. Is the segment present in the table?
2. Is the access kind allowed by the segment's permissions?
3. Does the offset lie inside the segment's length?

If all three pass, the base and the offset are added to form the physical address, and a memory access is issued one cycle later. If any step fails, no memory access is issued. Instead, a one-cycle fault pulse is raised, with a code that names the cause.

System software fills the descriptor table through a write port, one descriptor per cycle. A separate bound register limits how many segment numbers count as usable. This lets a short table be used without clearing the present flag of every unused descriptor.

Top module: `seg_xlate`

## Requirements
- R1: After reset, every descriptor is marked absent, the bound register holds 2^SEG_W, and both `mem_valid` and `fault_valid` are low.
- R2: A cycle with `dsc_we` high stores the present flag, the permissions, the length and the base into descriptor `dsc_sel`. The new values apply to every request presented in a later cycle.
- R3: A request whose segment has its present flag clear, or whose segment number is equal to or above the bound register, produces fault code 2'b01 (segment fault).
- R4: Each access kind needs one permission bit:
  - `acc_kind` 2'b00 (load) needs permission bit 0 (read);
  - 2'b01 (store) needs bit 1 (write);
  - 2'b10 (fetch) needs bit 2 (execute);
  - 2'b11 is never permitted.
  A request on a present segment that lacks the needed permission produces fault code 2'b10 (protection fault).
- R5: A request whose offset is equal to or above the segment length produces fault code 2'b01. A length of 0 faults every offset, and a length of 2^DISP_W accepts every offset.
- R6: A request that passes all checks raises `mem_valid` in the cycle after it is presented. In that cycle `mem_addr` = (base + offset) mod 2^PA_W, and `mem_kind` equals the request's `acc_kind`.
- R7: The checks have a fixed priority: presence first, then permission, then length. Each request produces exactly one outcome: either one memory access or one fault code.
- R8: A faulting request issues no memory access, and its `fault_valid` pulse lasts one cycle. A cycle with no request produces neither a memory access nor a fault.
- R9: A cycle with `bnd_we` high loads `bnd_val` into the bound register. Any later request with a segment number equal to or above that value takes a segment fault, even if its descriptor is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_req | input | 1 | A translation request is presented this cycle |
| acc_kind | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 reserved |
| acc_seg | input | SEG_W | Segment number of the request |
| acc_off | input | DISP_W | Offset within the segment |
| dsc_we | input | 1 | Write one descriptor |
| dsc_sel | input | SEG_W | Descriptor index to write |
| dsc_present | input | 1 | Present flag to store |
| dsc_perm | input | 3 | Permissions to store: bit0 read, bit1 write, bit2 execute |
| dsc_len | input | DISP_W+1 | Segment length in bytes |
| dsc_base | input | PA_W | Physical base address of the segment |
| bnd_we | input | 1 | Load the bound register |
| bnd_val | input | SEG_W+1 | New bound: number of usable segments |
| mem_valid | output | 1 | Memory access issued |
| mem_kind | output | 2 | Access kind of the issued access |
| mem_addr | output | PA_W | Translated physical address |
| fault_valid | output | 1 | One-cycle fault pulse |
| fault_code | output | 2 | 00 none, 01 segment fault, 10 protection fault |

## Verification
A corrupted descriptor cannot hide, because it surfaces at the ports one cycle after the first request that uses it:

- a wrong base shows up as a wrong `mem_addr`;
- a wrong length moves the point at which segment faults begin;
- a flipped permission bit turns a memory access into a protection fault, or the other way round.

The bench loads each of the eight permission patterns in turn. For each one, it sweeps every segment, every access kind and every offset, with lengths that include 0 and the full range. The check order and every permission bit are therefore exercised against arithmetic expectations. A wrong bound register turns whole segment numbers into faults, and this is covered by loading a reduced bound.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   typedef enum logic [1:0] {
      KIND_LOAD  = 2'b00,
      KIND_STORE = 2'b01,
      KIND_FETCH = 2'b10,
      KIND_RSVD  = 2'b11
   } kind_e;

   typedef enum logic [1:0] {
      FLT_NONE = 2'b00,
      FLT_SEG  = 2'b01,
      FLT_PROT = 2'b10
   } fault_e;

   localparam int PERM_RD = 0;
   localparam int PERM_WR = 1;
   localparam int PERM_EX = 2;
   localparam int PERM_W  = 3;

endpackage

// File: rtl/seg_desc_store.sv
module seg_desc_store
   import seg_xlate_pkg::*;
#(
   parameter int SEG_W   = 3,
   parameter int DISP_W  = 6,
   parameter int PA_W    = 10,
   parameter bit HAS_BND = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEG_W-1:0]  wr_sel,
   input  logic              wr_present,
   input  logic [PERM_W-1:0] wr_perm,
   input  logic [DISP_W:0]   wr_len,
   input  logic [PA_W-1:0]   wr_base,
   input  logic              bnd_en,
   input  logic [SEG_W:0]    bnd_in,
   input  logic [SEG_W-1:0]  rd_sel,
   output logic              rd_usable,
   output logic [PERM_W-1:0] rd_perm,
   output logic [DISP_W:0]   rd_len,
   output logic [PA_W-1:0]   rd_base
);
   localparam int NSEG = 1 << SEG_W;

   logic [NSEG-1:0]   ent_present;
   logic [PERM_W-1:0] ent_perm [NSEG];
   logic [DISP_W:0]   ent_len  [NSEG];
   logic [PA_W-1:0]   ent_base [NSEG];
   logic              sel_in_bound;

   for (genvar e = 0; e < NSEG; e++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_present[e] <= 1'b0;
            ent_perm[e]    <= '0;
            ent_len[e]     <= '0;
            ent_base[e]    <= '0;
         end else if (wr_en && (wr_sel == SEG_W'(e))) begin
            ent_present[e] <= wr_present;
            ent_perm[e]    <= wr_perm;
            ent_len[e]     <= wr_len;
            ent_base[e]    <= wr_base;
         end
      end
   end

   if (HAS_BND) begin : g_bound
      logic [SEG_W:0] bnd_q;
      always_ff @(posedge clk) begin
         if (!rst_n)      bnd_q <= (SEG_W+1)'(NSEG);
         else if (bnd_en) bnd_q <= bnd_in;
      end
      assign sel_in_bound = {1'b0, rd_sel} < bnd_q;

      assert_bound_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
         bnd_en |=> (bnd_q == $past(bnd_in)));
   end else begin : g_nobound
      assign sel_in_bound = 1'b1;
   end

   assign rd_usable = ent_present[rd_sel] && sel_in_bound;
   assign rd_perm   = ent_perm[rd_sel];
   assign rd_len    = ent_len[rd_sel];
   assign rd_base   = ent_base[rd_sel];

   assert_desc_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ent_base[$past(wr_sel)] == $past(wr_base)) &&
                (ent_len[$past(wr_sel)] == $past(wr_len)) &&
                (ent_present[$past(wr_sel)] == $past(wr_present)));

endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
   import seg_xlate_pkg::*;
#(
   parameter int DISP_W = 6,
   parameter int PA_W   = 10
) (
   input  logic [1:0]        kind,
   input  logic [DISP_W-1:0] off,
   input  logic              usable,
   input  logic [PERM_W-1:0] perm,
   input  logic [DISP_W:0]   len,
   input  logic [PA_W-1:0]   base,
   output fault_e            verdict,
   output logic [PA_W-1:0]   paddr
);
   logic perm_ok;
   logic in_len;

   always_comb begin
      case (kind)
         KIND_LOAD:  perm_ok = perm[PERM_RD];
         KIND_STORE: perm_ok = perm[PERM_WR];
         KIND_FETCH: perm_ok = perm[PERM_EX];
         default:    perm_ok = 1'b0;
      endcase
   end

   assign in_len = {1'b0, off} < len;

   always_comb begin
      if (!usable)       verdict = FLT_SEG;
      else if (!perm_ok) verdict = FLT_PROT;
      else if (!in_len)  verdict = FLT_SEG;
      else               verdict = FLT_NONE;
   end

   assign paddr = base + PA_W'(off);

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int SEG_W   = 3,
   parameter int DISP_W  = 6,
   parameter int PA_W    = 10,
   parameter bit HAS_BND = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_req,
   input  logic [1:0]        acc_kind,
   input  logic [SEG_W-1:0]  acc_seg,
   input  logic [DISP_W-1:0] acc_off,
   input  logic              dsc_we,
   input  logic [SEG_W-1:0]  dsc_sel,
   input  logic              dsc_present,
   input  logic [2:0]        dsc_perm,
   input  logic [DISP_W:0]   dsc_len,
   input  logic [PA_W-1:0]   dsc_base,
   input  logic              bnd_we,
   input  logic [SEG_W:0]    bnd_val,
   output logic              mem_valid,
   output logic [1:0]        mem_kind,
   output logic [PA_W-1:0]   mem_addr,
   output logic              fault_valid,
   output logic [1:0]        fault_code
);
   if (SEG_W < 1 || SEG_W > 8) begin : g_chk_seg
      $error("seg_xlate: SEG_W must lie in 1..8");
   end
   if (PA_W < DISP_W) begin : g_chk_pa
      $error("seg_xlate: PA_W must be at least DISP_W");
   end

   logic              rd_usable;
   logic [PERM_W-1:0] rd_perm;
   logic [DISP_W:0]   rd_len;
   logic [PA_W-1:0]   rd_base;
   fault_e            verdict;
   logic [PA_W-1:0]   paddr;

   seg_desc_store #(.SEG_W(SEG_W), .DISP_W(DISP_W), .PA_W(PA_W), .HAS_BND(HAS_BND)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(dsc_we), .wr_sel(dsc_sel), .wr_present(dsc_present),
      .wr_perm(dsc_perm), .wr_len(dsc_len), .wr_base(dsc_base),
      .bnd_en(bnd_we), .bnd_in(bnd_val),
      .rd_sel(acc_seg), .rd_usable(rd_usable), .rd_perm(rd_perm),
      .rd_len(rd_len), .rd_base(rd_base)
   );

   seg_access_check #(.DISP_W(DISP_W), .PA_W(PA_W)) u_check (
      .kind(acc_kind), .off(acc_off), .usable(rd_usable), .perm(rd_perm),
      .len(rd_len), .base(rd_base), .verdict(verdict), .paddr(paddr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_valid   <= 1'b0;
         mem_kind    <= 2'b00;
         mem_addr    <= '0;
         fault_valid <= 1'b0;
         fault_code  <= FLT_NONE;
      end else begin
         mem_valid   <= acc_req && (verdict == FLT_NONE);
         fault_valid <= acc_req && (verdict != FLT_NONE);
         fault_code  <= acc_req ? verdict : FLT_NONE;
         if (acc_req) begin
            mem_kind <= acc_kind;
            mem_addr <= paddr;
         end
      end
   end

   assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_valid, fault_valid}));

   assert_req_answered_R7: assert property (@(posedge clk) disable iff (!rst_n)
      acc_req |=> (mem_valid || fault_valid));

   assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid || fault_valid) |-> $past(acc_req));

   assert_fault_coded_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> (fault_code == FLT_SEG || fault_code == FLT_PROT));

   assert_within_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> ({1'b0, $past(acc_off)} < $past(rd_len)));

   assert_fetch_exec_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_kind == KIND_FETCH) |-> $past(rd_perm[PERM_EX]));

   assert_store_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_kind == KIND_STORE) |-> $past(rd_perm[PERM_WR]));

   assert_addr_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> (mem_addr == PA_W'($past(rd_base) + PA_W'($past(acc_off)))));

   assert_absent_faults_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req && !rd_usable) |=> (fault_valid && fault_code == FLT_SEG));

endmodule

// File: tb/sim_seg_xlate.sv
`timescale 1ns/1ps
module sim_seg_xlate;
   localparam int SEG_W  = 3;
   localparam int DISP_W = 6;
   localparam int PA_W   = 10;
   localparam int NSEG   = 1 << SEG_W;
   localparam int NOFF   = 1 << DISP_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              acc_req = 1'b0;
   logic [1:0]        acc_kind = '0;
   logic [SEG_W-1:0]  acc_seg = '0;
   logic [DISP_W-1:0] acc_off = '0;
   logic              dsc_we = 1'b0;
   logic [SEG_W-1:0]  dsc_sel = '0;
   logic              dsc_present = 1'b0;
   logic [2:0]        dsc_perm = '0;
   logic [DISP_W:0]   dsc_len = '0;
   logic [PA_W-1:0]   dsc_base = '0;
   logic              bnd_we = 1'b0;
   logic [SEG_W:0]    bnd_val = '0;
   logic              mem_valid;
   logic [1:0]        mem_kind;
   logic [PA_W-1:0]   mem_addr;
   logic              fault_valid;
   logic [1:0]        fault_code;

   int n_vec = 0;
   int n_bad = 0;

   int m_present [NSEG];
   int m_perm    [NSEG];
   int m_len     [NSEG];
   int m_base    [NSEG];
   int m_bnd     = NSEG;

   always #2 clk = ~clk;

   seg_xlate #(.SEG_W(SEG_W), .DISP_W(DISP_W), .PA_W(PA_W)) u0 (
      .clk(clk), .rst_n(rst_n),
      .acc_req(acc_req), .acc_kind(acc_kind), .acc_seg(acc_seg), .acc_off(acc_off),
      .dsc_we(dsc_we), .dsc_sel(dsc_sel), .dsc_present(dsc_present),
      .dsc_perm(dsc_perm), .dsc_len(dsc_len), .dsc_base(dsc_base),
      .bnd_we(bnd_we), .bnd_val(bnd_val),
      .mem_valid(mem_valid), .mem_kind(mem_kind), .mem_addr(mem_addr),
      .fault_valid(fault_valid), .fault_code(fault_code)
   );

   function automatic int expect_code(int s, int k, int off);
      int need;
      if (m_present[s] == 0 || s >= m_bnd) return 1;
      need = (k == 3) ? 0 : ((m_perm[s] >> k) & 1);
      if (need == 0) return 2;
      if (off >= m_len[s]) return 1;
      return 0;
   endfunction

   task automatic put_desc(int s, int pres, int perm, int len, int base);
      @(negedge clk);
      dsc_we = 1'b1; dsc_sel = SEG_W'(s); dsc_present = pres[0];
      dsc_perm = perm[2:0]; dsc_len = (DISP_W+1)'(len); dsc_base = PA_W'(base);
      @(negedge clk);
      dsc_we = 1'b0;
      m_present[s] = pres; m_perm[s] = perm; m_len[s] = len; m_base[s] = base;
   endtask

   task automatic put_bound(int b);
      @(negedge clk);
      bnd_we = 1'b1; bnd_val = (SEG_W+1)'(b);
      @(negedge clk);
      bnd_we = 1'b0;
      m_bnd = b;
   endtask

   task automatic probe(int s, int k, int off, string tag);
      int ec;
      int ea;
      @(negedge clk);
      acc_req = 1'b1; acc_kind = k[1:0]; acc_seg = SEG_W'(s); acc_off = DISP_W'(off);
      @(negedge clk);
      acc_req = 1'b0;
      ec = expect_code(s, k, off);
      ea = (m_base[s] + off) % (1 << PA_W);
      n_vec++;
      if (ec == 0) begin
         if (!mem_valid || fault_valid || mem_kind != k[1:0] || mem_addr != PA_W'(ea)) begin
            n_bad++;
            $display("FAIL %s seg=%0d kind=%0d off=%0d: mv=%0b fv=%0b kind=%0d addr=%0h, expected access kind=%0d addr=%0h",
                     tag, s, k, off, mem_valid, fault_valid, mem_kind, mem_addr, k, ea);
         end
      end else begin
         if (mem_valid || !fault_valid || fault_code != 2'(ec)) begin
            n_bad++;
            $display("FAIL %s seg=%0d kind=%0d off=%0d: mv=%0b fv=%0b code=%0d, expected fault code=%0d",
                     tag, s, k, off, mem_valid, fault_valid, fault_code, ec);
         end
      end
   endtask

   task automatic idle_check(string tag);
      @(negedge clk);
      n_vec++;
      if (mem_valid || fault_valid) begin
         n_bad++;
         $display("FAIL %s idle cycle: mv=%0b fv=%0b, expected 0 0", tag, mem_valid, fault_valid);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      for (int s = 0; s < NSEG; s++) begin
         m_present[s] = 0; m_perm[s] = 0; m_len[s] = 0; m_base[s] = 0;
      end
      repeat (3) @(negedge clk);
      // R1: outputs low while in reset
      n_vec++;
      if (mem_valid || fault_valid) begin
         n_bad++;
         $display("FAIL R1 reset outputs: mv=%0b fv=%0b, expected 0 0", mem_valid, fault_valid);
      end
      rst_n = 1'b1;
      // R1: every descriptor absent after reset
      for (int s = 0; s < NSEG; s++) probe(s, 0, 0, "R1");
      idle_check("R8");

      // R2 R3 R4 R5 R6 R7: full sweep for each permission pattern
      for (int p = 0; p < 8; p++) begin
         for (int s = 0; s < NSEG; s++)
            put_desc(s, (s == 5 && p % 2 == 0) ? 0 : 1, p,
                     (s * 9 + p * 5) % (NOFF + 1), (s * 97 + p * 31 + 700) % (1 << PA_W));
         for (int s = 0; s < NSEG; s++)
            for (int k = 0; k < 4; k++)
               for (int off = 0; off < NOFF; off++)
                  probe(s, k, off, "R2/R3/R4/R5/R6/R7");
         idle_check("R8");
      end

      // R5: length 0 and full length at the boundaries
      put_desc(2, 1, 7, 0, 1000);
      probe(2, 0, 0, "R5 zero length");
      put_desc(2, 1, 7, NOFF, 1000);
      probe(2, 0, NOFF - 1, "R5 full length wrap");
      probe(2, 2, 0, "R5 full length");

      // R9: reduced bound faults present segments at and above it
      for (int s = 0; s < NSEG; s++) put_desc(s, 1, 7, NOFF, s * 64);
      put_bound(5);
      for (int s = 0; s < NSEG; s++) probe(s, 1, 3, "R9");
      put_bound(0);
      probe(0, 0, 0, "R9 zero bound");
      put_bound(NSEG);
      probe(7, 2, 63, "R9 full bound");

      // R7: present, no permission, out of length -> protection wins
      put_desc(3, 1, 1, 4, 20);
      probe(3, 1, 10, "R7 priority");
      idle_check("R8");

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule